// File: doc/BRIEF.md
# Almost-Flag Offset Register Loader

This block owns the two thresholds that a FIFO uses for its early-warning flags. The first is an offset X, used for the near-empty warning on the read side. The second is an offset Y, used for the near-full warning on the write side. While reset is held, the block decodes how these offsets are to be filled:
- a fixed preset value,
- two words taken from the write-side data bus, or
- a serial bitstream clocked in on the write clock.

Once loading is finished, it raises a load-done output. From then on it lets write requests through to the FIFO storage.

The block also produces both warning flags. Each is registered in its own clock domain and is active low. The write-side flag goes low when the free-slot count is at or below Y. The read-side flag goes low when the stored-word count is at or below X. Both counts arrive as inputs that already belong to the right clock domain. The block does not count occupancy, cross pointers or store data.

The loader is a small state machine with four states:
- `ST_PAR_X`: waiting for the X word.
- `ST_PAR_Y`: waiting for the Y word.
- `ST_SERIAL`: shifting in bits.
- `ST_DONE`: offsets fixed.

The state is chosen while reset is held. The named transitions are:
- `PAR_X_TO_Y`: first bus write.
- `PAR_Y_TO_DONE`: second bus write.
- `SER_TO_DONE`: final serial bit.
- `RESET_DECODE`: any write-clock edge with reset low, which re-enters the state matching the configuration inputs.

Top module: `ofs_loader`

## Requirements
- R1: On every write-clock edge while `rst_n` is low, the method is decoded from `cfg_sel`/`cfg_mode`. A preset method loads its value into both offsets and reports `load_done`=1. The parallel and serial methods clear both offsets to 0 and report `load_done`=0.
- R2: The preset codes are `cfg_sel`=00 for 8, 01 for 16 and 10 for 64, and the value is written to both X and Y. `cfg_sel`=11 selects the bus method with `cfg_mode`=0 and the serial method with `cfg_mode`=1.
- R3: In the bus method, the first write-clock edge after reset with `wr_en`=1 loads X from `wr_word`. The second such edge loads Y and raises `load_done` after that edge.
- R4: `fifo_wr` equals `wr_en` only while `rst_n`=1 and `load_done`=1, and is 0 otherwise. A write in the same cycle as the final load step is therefore not forwarded.
- R5: In the serial method, each write-clock edge with `ser_en_n`=0 shifts `ser_din` into the chain {Y,X}, entering at the X LSB. After 2·AW bits, the first bit sits in the Y MSB and the last bit in the X LSB. Edges with `ser_en_n`=1 shift nothing.
- R6: `load_done` rises after the edge that takes serial bit number 2·AW. While `load_done`=1, activity on `ser_en_n`, `ser_din` and `wr_en` leaves X, Y and `load_done` unchanged.
- R7: `alm_full_n` is registered on `wclk`. After each edge it equals NOT(`free_slots` ≤ Y), with both values taken at that edge. It is 1 during reset.
- R8: `alm_empty_n` is registered on `rclk`. After each edge it equals NOT(`fill_words` ≤ X), with both values taken at that edge. It is 0 during reset.
- R9: Before loading ends, serial-enable activity in the bus method leaves X and Y unchanged. With `wr_en`=0 and `ser_en_n`=1, the offsets never change outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, held across several edges of both clocks |
| cfg_sel | input | 2 | Method/preset select, decoded during reset |
| cfg_mode | input | 1 | Bus (0) or serial (1) method when `cfg_sel`=11 |
| wr_en | input | 1 | Write request on the write side |
| wr_word | input | AW | Offset-width low slice of the write data bus |
| ser_en_n | input | 1 | Serial shift enable, active low |
| ser_din | input | 1 | Serial offset data |
| free_slots | input | AW+1 | Free locations, write-clock domain |
| fill_words | input | AW+1 | Stored words, read-clock domain |
| x_ofs | output | AW | Near-empty offset X |
| y_ofs | output | AW | Near-full offset Y |
| load_done | output | 1 | Offsets are loaded and fixed |
| fifo_wr | output | 1 | Write request passed to FIFO storage |
| alm_full_n | output | 1 | Near-full flag, active low, `wclk` domain |
| alm_empty_n | output | 1 | Near-empty flag, active low, `rclk` domain |

## Verification
Two functions can meet in the same cycle: the last load step (second bus word or final serial bit) and a FIFO write request or a near-full comparison.

The bench provokes this by holding `wr_en` high during the final serial bit. It also holds `free_slots` at 5 while the second bus word moves Y from 0 to 0x3C.

It then judges three results:
- `fifo_wr` stays 0 in that cycle and rises in the next one.
- The flag computed at the loading edge still uses the old Y, so it reads 1.
- The next edge uses the new Y, so it reads 0.

// File: rtl/ofs_ld_pkg.sv
package ofs_ld_pkg;

    typedef enum logic [1:0] {
        ST_PAR_X  = 2'd0,
        ST_PAR_Y  = 2'd1,
        ST_SERIAL = 2'd2,
        ST_DONE   = 2'd3
    } ld_state_t;

    typedef enum logic [2:0] {
        OP_HOLD   = 3'd0,
        OP_CLEAR  = 3'd1,
        OP_PRESET = 3'd2,
        OP_LD_X   = 3'd3,
        OP_LD_Y   = 3'd4,
        OP_SHIFT  = 3'd5
    } reg_op_t;

    typedef enum logic [1:0] {
        MTH_PRESET   = 2'd0,
        MTH_PARALLEL = 2'd1,
        MTH_SERIAL   = 2'd2
    } method_t;

    function automatic method_t decode_method(input logic [1:0] sel, input logic mode);
        if (sel != 2'b11)
            return MTH_PRESET;
        else if (mode)
            return MTH_SERIAL;
        else
            return MTH_PARALLEL;
    endfunction

    function automatic int unsigned preset_value(input logic [1:0] sel);
        unique case (sel)
            2'b00:   return 8;
            2'b01:   return 16;
            default: return 64;
        endcase
    endfunction

endpackage

// File: rtl/ofs_load_fsm.sv
module ofs_load_fsm
    import ofs_ld_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_sel,
    input  logic       cfg_mode,
    input  logic       wr_en,
    input  logic       ser_en_n,
    output reg_op_t    op,
    output logic       load_done,
    output logic       fifo_wr
);
    localparam int unsigned NBITS = 2 * AW;
    localparam int unsigned CNT_W = $clog2(NBITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(NBITS - 1);

    ld_state_t        state_q, state_nx, entry_state;
    logic [CNT_W-1:0] bit_cnt_q;
    method_t          method;

    // Method decode used by RESET_DECODE
    always_comb begin
        method = decode_method(cfg_sel, cfg_mode);
        unique case (method)
            MTH_PRESET:   entry_state = ST_DONE;
            MTH_PARALLEL: entry_state = ST_PAR_X;
            default:      entry_state = ST_SERIAL;
        endcase
    end

    // Next state: PAR_X_TO_Y, PAR_Y_TO_DONE, SER_TO_DONE
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_PAR_X:  if (wr_en) state_nx = ST_PAR_Y;
            ST_PAR_Y:  if (wr_en) state_nx = ST_DONE;
            ST_SERIAL: if (!ser_en_n && bit_cnt_q == LAST_BIT) state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_DONE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= entry_state;
            bit_cnt_q <= '0;
        end else begin
            state_q <= state_nx;
            if (op == OP_SHIFT)
                bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        op        = OP_HOLD;
        load_done = (state_q == ST_DONE);
        fifo_wr   = 1'b0;
        if (!rst_n) begin
            op = (method == MTH_PRESET) ? OP_PRESET : OP_CLEAR;
        end else begin
            unique case (state_q)
                ST_PAR_X:  if (wr_en) op = OP_LD_X;
                ST_PAR_Y:  if (wr_en) op = OP_LD_Y;
                ST_SERIAL: if (!ser_en_n) op = OP_SHIFT;
                ST_DONE:   fifo_wr = wr_en;
            endcase
        end
    end

endmodule

// File: rtl/ofs_store.sv
module ofs_store
    import ofs_ld_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  reg_op_t       op,
    input  logic [1:0]    preset_sel,
    input  logic [AW-1:0] wr_word,
    input  logic          ser_din,
    output logic [AW-1:0] x_q,
    output logic [AW-1:0] y_q
);
    logic [AW-1:0] preset_w;

    assign preset_w = AW'(preset_value(preset_sel));

    always_ff @(posedge clk) begin
        unique case (op)
            OP_CLEAR: begin
                x_q <= '0;
                y_q <= '0;
            end
            OP_PRESET: begin
                x_q <= preset_w;
                y_q <= preset_w;
            end
            OP_LD_X:  x_q <= wr_word;
            OP_LD_Y:  y_q <= wr_word;
            OP_SHIFT: {y_q, x_q} <= {y_q[AW-2:0], x_q, ser_din};
            default: begin
                x_q <= x_q;
                y_q <= y_q;
            end
        endcase
    end

endmodule

// File: rtl/almost_flag.sv
module almost_flag #(
    parameter int unsigned LW      = 9,
    parameter int unsigned TW      = 8,
    parameter bit          RST_VAL = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] level,
    input  logic [TW-1:0] thresh,
    output logic          flag_n
);
    logic [LW-1:0] thresh_ext;

    assign thresh_ext = {{(LW-TW){1'b0}}, thresh};

    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_n <= RST_VAL;
        else
            flag_n <= !(level <= thresh_ext);
    end

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
    import ofs_ld_pkg::*;
#(
    parameter  int unsigned DEPTH = 256,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_sel,
    input  logic          cfg_mode,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_word,
    input  logic          ser_en_n,
    input  logic          ser_din,
    input  logic [AW:0]   free_slots,
    input  logic [AW:0]   fill_words,
    output logic [AW-1:0] x_ofs,
    output logic [AW-1:0] y_ofs,
    output logic          load_done,
    output logic          fifo_wr,
    output logic          alm_full_n,
    output logic          alm_empty_n
);
    reg_op_t       op;
    logic [AW-1:0] x_q, y_q;
    logic [1:0]    flag_n;

    ofs_load_fsm #(.AW(AW)) u_fsm (
        .clk       (wclk),
        .rst_n     (rst_n),
        .cfg_sel   (cfg_sel),
        .cfg_mode  (cfg_mode),
        .wr_en     (wr_en),
        .ser_en_n  (ser_en_n),
        .op        (op),
        .load_done (load_done),
        .fifo_wr   (fifo_wr)
    );

    ofs_store #(.AW(AW)) u_store (
        .clk        (wclk),
        .op         (op),
        .preset_sel (cfg_sel),
        .wr_word    (wr_word),
        .ser_din    (ser_din),
        .x_q        (x_q),
        .y_q        (y_q)
    );

    // Index 0: near-full on the write side; index 1: near-empty on the read side
    for (genvar g = 0; g < 2; g++) begin : g_flag
        localparam bit IS_FULL = (g == 0);
        almost_flag #(
            .LW      (AW + 1),
            .TW      (AW),
            .RST_VAL (IS_FULL)
        ) u_flag (
            .clk    (IS_FULL ? wclk : rclk),
            .rst_n  (rst_n),
            .level  (IS_FULL ? free_slots : fill_words),
            .thresh (IS_FULL ? y_q : x_q),
            .flag_n (flag_n[g])
        );
    end

    assign x_ofs       = x_q;
    assign y_ofs       = y_q;
    assign alm_full_n  = flag_n[0];
    assign alm_empty_n = flag_n[1];

endmodule

// File: rtl/ofs_loader_chk.sv
module ofs_loader_chk #(
    parameter int unsigned AW = 8
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          ser_en_n,
    input logic [AW:0]   free_slots,
    input logic [AW:0]   fill_words,
    input logic [AW-1:0] x_ofs,
    input logic [AW-1:0] y_ofs,
    input logic          load_done,
    input logic          fifo_wr,
    input logic          alm_full_n,
    input logic          alm_empty_n
);
    // R4
    a_r4_fifo_wr_needs_done: assert property (@(posedge wclk) disable iff (!rst_n)
        fifo_wr |-> (load_done && wr_en));

    // R6
    a_r6_offsets_frozen_when_done: assert property (@(posedge wclk) disable iff (!rst_n)
        load_done |=> (load_done && $stable(x_ofs) && $stable(y_ofs)));

    // R7
    a_r7_full_flag_tracks: assert property (@(posedge wclk) disable iff (!rst_n)
        rst_n |=> (alm_full_n == !($past(free_slots) <= {1'b0, $past(y_ofs)})));

    // R8
    a_r8_empty_flag_tracks: assert property (@(posedge rclk) disable iff (!rst_n)
        rst_n |=> (alm_empty_n == !($past(fill_words) <= {1'b0, $past(x_ofs)})));

    // R9
    a_r9_idle_keeps_offsets: assert property (@(posedge wclk) disable iff (!rst_n)
        (!wr_en && ser_en_n) |=> ($stable(x_ofs) && $stable(y_ofs)));

endmodule

bind ofs_loader ofs_loader_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_ofs_loader.sv
module tb_ofs_loader;
    localparam int unsigned DEPTH = 256;
    localparam int unsigned AW    = 8;

    logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
    logic [1:0]    cfg_sel = 2'b00;
    logic          cfg_mode = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_word = '0;
    logic          ser_en_n = 1'b1, ser_din = 1'b0;
    logic [AW:0]   free_slots = (AW+1)'(DEPTH);
    logic [AW:0]   fill_words = '0;
    logic [AW-1:0] x_ofs, y_ofs;
    logic          load_done, fifo_wr, alm_full_n, alm_empty_n;

    int checks = 0;
    int fails  = 0;

    always #10 wclk = ~wclk;
    always #7  rclk = ~rclk;

    ofs_loader #(.DEPTH(DEPTH)) dut (.*);

    typedef enum int {SIG_X, SIG_Y, SIG_DONE, SIG_AFULL} sig_t;
    typedef struct {
        string       req;
        sig_t        sig;
        logic [31:0] exp;
    } item_t;
    item_t sbq[$];

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // Driver side: expectation for the outputs after the next write-clock edge
    task automatic expect_w(input string req, input sig_t sig, input logic [31:0] v);
        item_t it;
        it.req = req; it.sig = sig; it.exp = v;
        sbq.push_back(it);
    endtask

    // Monitor: 5 ns after each write-clock edge, compare all queued items
    initial begin
        forever begin
            @(posedge wclk);
            #5;
            while (sbq.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sbq.pop_front();
                unique case (it.sig)
                    SIG_X:    act = 32'(x_ofs);
                    SIG_Y:    act = 32'(y_ofs);
                    SIG_DONE: act = 32'(load_done);
                    default:  act = 32'(alm_full_n);
                endcase
                check(it.req, it.sig.name(), act, it.exp);
            end
        end
    end

    task automatic cyc();
        @(negedge wclk);
    endtask

    task automatic do_reset(input logic [1:0] sel, input logic mode, input int unsigned xv, input logic dn);
        rst_n = 1'b0; cfg_sel = sel; cfg_mode = mode;
        wr_en = 1'b0; ser_en_n = 1'b1; fill_words = '0; free_slots = (AW+1)'(DEPTH);
        repeat (3) cyc();
        // R1 / R2: decode while reset is held
        expect_w("R1", SIG_X, xv);
        expect_w("R1", SIG_Y, xv);
        expect_w("R1", SIG_DONE, 32'(dn));
        cyc();
        check("R7", "alm_full_n in reset", 32'(alm_full_n), 1);
        check("R8", "alm_empty_n in reset", 32'(alm_empty_n), 0);
        rst_n = 1'b1;
    endtask

    task automatic rchk(input string req, input int unsigned fill, input logic exp);
        @(negedge rclk);
        fill_words = (AW+1)'(fill);
        @(posedge rclk);
        #2;
        check(req, "alm_empty_n", 32'(alm_empty_n), 32'(exp));
    endtask

    task automatic wflag(input string req, input int unsigned free, input logic exp);
        free_slots = (AW+1)'(free);
        expect_w(req, SIG_AFULL, 32'(exp));
        cyc();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog act=timeout exp=completion");
        finish_run();
    end

    initial begin
        logic [15:0] stream;
        cyc();

        // ---------- preset 8 ----------
        do_reset(2'b00, 1'b0, 8, 1'b1);
        cyc();
        wflag("R7", 9, 1'b1);
        wflag("R7", 8, 1'b0);
        wflag("R7", 0, 1'b0);
        wflag("R7", 200, 1'b1);
        rchk("R8", 8, 1'b0);
        rchk("R8", 9, 1'b1);
        rchk("R8", 0, 1'b0);
        cyc();
        // R6: serial activity after load_done ignored; R4 writes forwarded
        ser_en_n = 1'b0; ser_din = 1'b1; wr_en = 1'b1;
        #1 check("R4", "fifo_wr after preset", 32'(fifo_wr), 1);
        expect_w("R6", SIG_X, 8); expect_w("R6", SIG_Y, 8); expect_w("R6", SIG_DONE, 1);
        cyc();
        ser_din = 1'b0;
        expect_w("R6", SIG_X, 8); expect_w("R6", SIG_Y, 8);
        cyc();
        ser_en_n = 1'b1; wr_en = 1'b0;
        #1 check("R4", "fifo_wr idle", 32'(fifo_wr), 0);

        // ---------- preset 16 and 64 ----------
        do_reset(2'b01, 1'b0, 16, 1'b1);
        cyc();
        do_reset(2'b10, 1'b0, 64, 1'b1);
        cyc();
        wflag("R7", 65, 1'b1);
        wflag("R7", 64, 1'b0);
        rchk("R8", 64, 1'b0);
        rchk("R8", 65, 1'b1);

        // ---------- parallel method ----------
        do_reset(2'b11, 1'b0, 0, 1'b0);
        free_slots = 5;
        // R9: serial enable ignored in bus method
        ser_en_n = 1'b0; ser_din = 1'b1;
        expect_w("R9", SIG_X, 0); expect_w("R9", SIG_Y, 0); expect_w("R9", SIG_AFULL, 1);
        cyc();
        expect_w("R9", SIG_X, 0); expect_w("R9", SIG_Y, 0);
        cyc();
        ser_en_n = 1'b1;
        wr_en = 1'b1; wr_word = 8'hA5;
        #1 check("R4", "fifo_wr on X word", 32'(fifo_wr), 0);
        expect_w("R3", SIG_X, 32'hA5); expect_w("R3", SIG_Y, 0); expect_w("R3", SIG_DONE, 0);
        cyc();
        wr_word = 8'h3C;
        #1 check("R4", "fifo_wr on Y word", 32'(fifo_wr), 0);
        // same-cycle: Y load and near-full compare use old Y (0)
        expect_w("R3", SIG_Y, 32'h3C); expect_w("R3", SIG_X, 32'hA5);
        expect_w("R3", SIG_DONE, 1); expect_w("R7", SIG_AFULL, 1);
        cyc();
        wr_word = 8'hFF;
        #1 check("R4", "fifo_wr after bus load", 32'(fifo_wr), 1);
        expect_w("R7", SIG_AFULL, 0); expect_w("R6", SIG_X, 32'hA5); expect_w("R6", SIG_Y, 32'h3C);
        cyc();
        wr_en = 1'b0;
        wflag("R7", 32'h3C, 1'b0);
        wflag("R7", 32'h3D, 1'b1);
        rchk("R8", 32'hA5, 1'b0);
        rchk("R8", 32'hA6, 1'b1);
        cyc();

        // ---------- serial method ----------
        do_reset(2'b11, 1'b1, 0, 1'b0);
        stream = {8'h96, 8'h2D};
        for (int i = 15; i >= 0; i--) begin
            ser_en_n = 1'b0; ser_din = stream[i];
            wr_en = (i == 0) || (i == 10);
            #1 check("R4", "fifo_wr during serial", 32'(fifo_wr), 0);
            if (i == 8) begin
                // R5: after eight bits the first byte has moved through X
                expect_w("R5", SIG_X, 32'h96); expect_w("R5", SIG_Y, 0);
            end
            if (i == 1) expect_w("R6", SIG_DONE, 0);
            if (i == 0) begin
                expect_w("R5", SIG_X, 32'h2D); expect_w("R5", SIG_Y, 32'h96);
                expect_w("R6", SIG_DONE, 1);
            end
            cyc();
            if (i == 12) begin
                // gap: no shift with enable high
                ser_en_n = 1'b1; ser_din = ~ser_din; wr_en = 1'b0;
                cyc();
            end
        end
        wr_en = 1'b1;
        #1 check("R4", "fifo_wr after serial load", 32'(fifo_wr), 1);
        ser_din = 1'b1;
        for (int k = 0; k < 5; k++) begin
            expect_w("R6", SIG_X, 32'h2D); expect_w("R6", SIG_Y, 32'h96); expect_w("R6", SIG_DONE, 1);
            cyc();
        end
        ser_en_n = 1'b1; wr_en = 1'b0;
        rchk("R8", 32'h2D, 1'b0);
        rchk("R8", 32'h2E, 1'b1);
        cyc();
        wflag("R7", 32'h96, 1'b0);
        wflag("R7", 32'h97, 1'b1);
        cyc();
        cyc();
        finish_run();
    end

endmodule